// File: doc/BRIEF.md
# ATA Multiword DMA Host Sequencer

This block is the host end of an ATA multiword DMA transfer running at Mode 2 speed. Software or a command engine loads a word count and a direction, then pulses `start`. The sequencer waits for the device to raise its DMA request and then asserts the acknowledge. It paces the read or write strobes with counts derived from the system clock period, so that strobe width, strobe recovery and full cycle time meet the Mode 2 minimums. It moves one 16-bit word per strobe over a split in/out/enable data bus.

On the user side, write words enter through a valid/ready pair. Read words leave as a one-cycle valid pulse. The device can cut a burst short by dropping its request. The sequencer looks at the request once per word, during the recovery gap after each strobe. When a burst finishes, the sequencer holds the acknowledge for the hold time, releases it, and pulses `done` with the number of words that actually moved. Chip selects stay negated for the whole time, as DMA transfers require.

Every time limit is a parameter in nanoseconds. Each one becomes a cycle count by rounding up against the clock period parameter. The recovery count is stretched where needed so that strobe-on plus recovery covers the full cycle time.

Top module: `ata_mdma_host`

## Requirements
- R1: While and just after reset, `dmack_n`, `dior_n` and `diow_n` are high, `dd_oe`, `busy`, `done`, `rd_valid` and `wr_ready` are low, and `cs_n` is 2'b11.
- R2: Each strobe (`dior_n` or `diow_n`) stays low for exactly N_D = ceil(70 ns / clock period) cycles. At the default 4 ns clock this is 18 cycles.
- R3: When data is ready and `dmarq` stays high, successive strobe falling edges are N_D + N_NEG cycles apart. N_NEG = max(ceil(25/T), ceil(120/T) - N_D), which is 12 at 4 ns, giving a period of 30 cycles.
- R4: `dmack_n` goes low exactly N_I = ceil(20/T) = 5 cycles before the first strobe falls. After the last strobe of a burst that ends on its count, `dmack_n` stays low exactly N_J = ceil(10/T) = 3 cycles. A strobe is never low while `dmack_n` is high.
- R5: In a read burst (`dir_rd`=1), `dd_in` is captured on the clock edge at which `dior_n` rises. The captured word appears on `rd_data` with `rd_valid` high for one cycle, and words arrive in strobe order.
- R6: In a write burst, each word taken by a `wr_valid`&`wr_ready` handshake is on `dd_out` with `dd_oe` high when its `diow_n` rises. `dd_oe` is low whenever `dmack_n` is high.
- R7: If no write word is offered, `diow_n` stays high and `dmack_n` stays low until one arrives. The burst then resumes with no word lost.
- R8: A burst stops after `word_cnt` words. `done` pulses for one cycle with `dmack_n` high, and `words_done` equals the count.
- R9: If `dmarq` is low in the gap after a strobe, the burst ends early, and `words_done` reports the words already moved.
- R10: After `start`, `dmack_n` stays high and `busy` high until `dmarq` is high.
- R11: A `start` with `word_cnt` = 0, or a `start` while `busy` is high, is ignored.
- R12: Only the strobe matching the direction of the burst is ever driven low, and `cs_n` stays 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (accepted only when idle) |
| dir_rd | input | 1 | 1 = device-to-host read, 0 = host-to-device write |
| word_cnt | input | CNT_W | Number of words in the burst |
| wr_data | input | DW | Write word from user |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken on this edge |
| rd_data | output | DW | Read word to user |
| rd_valid | output | 1 | Read word valid, one-cycle pulse |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| words_done | output | CNT_W | Words moved by the last burst |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, held negated |
| dd_in | input | DW | Data bus input from pads |
| dd_out | output | DW | Data bus output to pads |
| dd_oe | output | 1 | Data bus output enable |

## Verification
Read bursts with a steady request are used to measure strobe width, strobe period and the setup and hold of acknowledge. Their captured words are compared in order against what the device model drove. Write bursts run both with words always offered and with a long gap in the middle. This separates correct stalling (strobe held high, acknowledge held low, no word dropped) from running ahead on stale data. A burst that starts before the device asks, a request dropped after the second word, a one-word burst, and starts given with zero count or mid-burst test that the burst begins and ends under the right conditions.

// File: rtl/ata_mdma_pkg.sv
package ata_mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ACK_SETUP,
        ST_STB_ON,
        ST_STB_OFF,
        ST_CHECK,
        ST_ACK_HOLD
    } mdma_state_e;

    // Pin intent for the next cycle, active-high
    typedef struct packed {
        logic ack;
        logic rd_stb;
        logic wr_stb;
        logic drive;
    } bus_ctl_t;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mdma_phase_timer.sv
module mdma_phase_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/mdma_seq_fsm.sv
module mdma_seq_fsm
    import ata_mdma_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int N_I   = 5,
    parameter int N_D   = 18,
    parameter int N_NEG = 12,
    parameter int N_J   = 3,
    parameter int TW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_rd,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic             dmarq,
    input  logic             wr_valid,
    input  logic             expired,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output bus_ctl_t         ctl_next,
    output logic             wr_take,
    output logic             rd_capture,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] words_done
);
    localparam int N_OFF = (N_NEG > 1) ? N_NEG - 1 : 1;

    mdma_state_e      state, state_n;
    logic             dir_q;
    logic [CNT_W-1:0] remain;
    logic             data_ok;

    assign data_ok = dir_q || wr_valid;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (start && word_cnt != '0) state_n = ST_ARMED;
            ST_ARMED:     if (dmarq) state_n = ST_ACK_SETUP;
            ST_ACK_SETUP: if (expired && data_ok) state_n = ST_STB_ON;
            ST_STB_ON:    if (expired) state_n = (remain == 1) ? ST_ACK_HOLD : ST_STB_OFF;
            ST_STB_OFF:   if (expired) state_n = ST_CHECK;
            ST_CHECK: begin
                if (!dmarq)       state_n = ST_ACK_HOLD;
                else if (data_ok) state_n = ST_STB_ON;
            end
            ST_ACK_HOLD:  if (expired) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    function automatic logic [TW-1:0] phase_len_m1(mdma_state_e s);
        case (s)
            ST_ACK_SETUP: return TW'(N_I - 1);
            ST_STB_ON:    return TW'(N_D - 1);
            ST_STB_OFF:   return TW'(N_OFF - 1);
            ST_ACK_HOLD:  return TW'(N_J - 1);
            default:      return '0;
        endcase
    endfunction

    assign tmr_load   = (state_n != state);
    assign tmr_val    = phase_len_m1(state_n);
    assign wr_take    = (state_n == ST_STB_ON) && (state != ST_STB_ON) && !dir_q;
    assign rd_capture = (state == ST_STB_ON) && expired && dir_q;

    always_comb begin
        ctl_next        = '0;
        ctl_next.ack    = (state_n != ST_IDLE) && (state_n != ST_ARMED);
        ctl_next.rd_stb = (state_n == ST_STB_ON) && dir_q;
        ctl_next.wr_stb = (state_n == ST_STB_ON) && !dir_q;
        ctl_next.drive  = ctl_next.ack && !dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dir_q      <= 1'b0;
            remain     <= '0;
            words_done <= '0;
            done       <= 1'b0;
        end else begin
            state <= state_n;
            done  <= (state == ST_ACK_HOLD) && (state_n == ST_IDLE);
            if (state == ST_IDLE && state_n == ST_ARMED) begin
                dir_q      <= dir_rd;
                remain     <= word_cnt;
                words_done <= '0;
            end else if (state == ST_STB_ON && expired) begin
                remain     <= remain - 1'b1;
                words_done <= words_done + 1'b1;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11: zero-count start leaves the sequencer idle
    a_r11_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && word_cnt == '0) |=> (state == ST_IDLE));
    // R7: a write strobe never begins without a taken word
    a_r7_no_empty_write: assert property (@(posedge clk) disable iff (rst)
        (ctl_next.wr_stb && state != ST_STB_ON) |-> wr_valid);
endmodule

// File: rtl/mdma_bus_io.sv
module mdma_bus_io
    import ata_mdma_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ctl_t      ctl_next,
    input  logic          wr_take,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_capture,
    input  logic [DW-1:0] dd_in,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          dmack_n,
    output logic          dior_n,
    output logic          diow_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dmack_n  <= 1'b1;
            dior_n   <= 1'b1;
            diow_n   <= 1'b1;
            dd_oe    <= 1'b0;
            dd_out   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            dmack_n  <= !ctl_next.ack;
            dior_n   <= !ctl_next.rd_stb;
            diow_n   <= !ctl_next.wr_stb;
            dd_oe    <= ctl_next.drive;
            rd_valid <= rd_capture;
            if (wr_take)    dd_out  <= wr_data;
            if (rd_capture) rd_data <= dd_in;
        end
    end

    // R12: never both strobes at once
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
        dior_n || diow_n);
    // R4: strobes only inside the acknowledge window
    a_r4_strobe_in_ack: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> !dmack_n);
    // R4: acknowledge releases only after strobes were already high
    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        $rose(dmack_n) |-> ($past(dior_n) && $past(diow_n)));
    // R6: bus driven only while acknowledged
    a_r6_oe_in_burst: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> !dmack_n);
endmodule

// File: rtl/ata_mdma_host.sv
module ata_mdma_host
    import ata_mdma_pkg::*;
#(
    parameter int CLK_NS       = 4,
    parameter int T_CYCLE_NS   = 120,
    parameter int T_STB_ON_NS  = 70,
    parameter int T_STB_OFF_NS = 25,
    parameter int T_ACK_SU_NS  = 20,
    parameter int T_ACK_HD_NS  = 10,
    parameter int DW           = 16,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_rd,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] words_done,
    input  logic             dmarq,
    output logic             dmack_n,
    output logic             dior_n,
    output logic             diow_n,
    output logic [1:0]       cs_n,
    input  logic [DW-1:0]    dd_in,
    output logic [DW-1:0]    dd_out,
    output logic             dd_oe
);
    localparam int N_D   = ns_to_cyc(T_STB_ON_NS, CLK_NS);
    localparam int N_K   = ns_to_cyc(T_STB_OFF_NS, CLK_NS);
    localparam int N_0   = ns_to_cyc(T_CYCLE_NS, CLK_NS);
    localparam int N_NEG = max2(N_K, (N_0 > N_D) ? N_0 - N_D : 1);
    localparam int N_I   = ns_to_cyc(T_ACK_SU_NS, CLK_NS);
    localparam int N_J   = ns_to_cyc(T_ACK_HD_NS, CLK_NS);
    localparam int N_MAX = max2(max2(N_D, N_NEG), max2(N_I, N_J));
    localparam int TW    = $clog2(N_MAX + 1) + 1;

    bus_ctl_t       ctl_next;
    logic           tmr_load, expired, wr_take, rd_capture;
    logic [TW-1:0]  tmr_val;

    mdma_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    mdma_seq_fsm #(
        .CNT_W(CNT_W), .N_I(N_I), .N_D(N_D), .N_NEG(N_NEG), .N_J(N_J), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .dir_rd(dir_rd), .word_cnt(word_cnt),
        .dmarq(dmarq), .wr_valid(wr_valid), .expired(expired),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .ctl_next(ctl_next),
        .wr_take(wr_take), .rd_capture(rd_capture), .busy(busy),
        .done(done), .words_done(words_done)
    );

    mdma_bus_io #(.DW(DW)) u_io (
        .clk(clk), .rst(rst), .ctl_next(ctl_next), .wr_take(wr_take),
        .wr_data(wr_data), .rd_capture(rd_capture), .dd_in(dd_in),
        .dd_out(dd_out), .dd_oe(dd_oe), .rd_data(rd_data), .rd_valid(rd_valid),
        .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n)
    );

    assign wr_ready = wr_take;
    assign cs_n     = 2'b11;

    // Strobe low-time measurement for the width check
    localparam int LW = $clog2(N_D + 2) + 1;
    logic          stb_low, stb_low_q;
    logic [LW-1:0] low_run;
    assign stb_low = !dior_n || !diow_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            stb_low_q <= 1'b0;
        end else begin
            stb_low_q <= stb_low;
            low_run   <= stb_low ? low_run + 1'b1 : '0;
        end
    end

    // R2: every strobe lasts exactly N_D cycles
    a_r2_width: assert property (@(posedge clk) disable iff (rst)
        (stb_low_q && !stb_low) |-> (low_run == LW'(N_D)));
    // R5: a read word appears just as the read strobe rises
    a_r5_rd_on_rise: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (dior_n && $past(!dior_n)));
endmodule

// File: tb/ata_mdma_host_bench.sv
module ata_mdma_host_bench;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int EXP_D = 18, EXP_PER = 30, EXP_SU = 5, EXP_HD = 3;

    logic clk = 0, rst = 1;
    logic start = 0, dir_rd = 0, wr_valid = 0, dmarq = 0;
    logic [CW-1:0] word_cnt = '0;
    logic [DW-1:0] wr_data = '0, dd_in = '0;
    logic wr_ready, rd_valid, busy, done, dmack_n, dior_n, diow_n, dd_oe;
    logic [DW-1:0] rd_data, dd_out;
    logic [CW-1:0] words_done;
    logic [1:0] cs_n;

    ata_mdma_host u_ata_mdma_host (
        .clk(clk), .rst(rst), .start(start), .dir_rd(dir_rd), .word_cnt(word_cnt),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .words_done(words_done), .dmarq(dmarq), .dmack_n(dmack_n),
        .dior_n(dior_n), .diow_n(diow_n), .cs_n(cs_n), .dd_in(dd_in),
        .dd_out(dd_out), .dd_oe(dd_oe)
    );

    always #2 clk = ~clk;

    int tests = 0, fails = 0;
    logic [DW-1:0] rq[$];
    logic [DW-1:0] wq[$];
    int dev_idx = 0, stop_at = -1;
    bit per_chk = 1, hd_chk = 1, expect_wr = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dev_word(int i);
        return 16'hC000 ^ DW'(i * 16'h0137);
    endfunction

    // Device model and scoreboard monitor, sampled on the falling clock edge
    bit prev_low = 0, prev_rd_low = 0, prev_wr_low = 0, prev_ack = 0, seen = 0;
    int low_run = 0, since = 0, su_run = 0, hd_run = 0, nstb = 0;
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit low = !dior_n || !diow_n;
            automatic bit ack = !dmack_n;
            if (cs_n != 2'b11) chk(0, "R12", "cs_n", cs_n, 3);
            if (!diow_n && expect_wr == 0) chk(0, "R12", "write strobe in read burst", 0, 1);
            if (!dior_n && expect_wr == 1) chk(0, "R12", "read strobe in write burst", 0, 1);
            if (low && !prev_low) begin
                if (!seen) chk(su_run == EXP_SU, "R4", "ack setup cycles", su_run, EXP_SU);
                else if (per_chk) chk(since == EXP_PER, "R3", "strobe period", since, EXP_PER);
                seen = 1; since = 1; nstb++;
                if (!dior_n) begin dd_in = dev_word(dev_idx); dev_idx++; end
                if (nstb == stop_at) dmarq = 0;
            end else since++;
            if (low) begin low_run++; hd_run = 0; end
            else begin
                if (prev_low) chk(low_run == EXP_D, "R2", "strobe width", low_run, EXP_D);
                low_run = 0;
            end
            if (ack && !low && !seen) su_run++;
            if (ack && !low && seen) hd_run++;
            if (prev_wr_low && diow_n) begin
                if (wq.size() == 0) chk(0, "R6", "unexpected write word", dd_out, 0);
                else begin
                    automatic logic [DW-1:0] e = wq.pop_front();
                    chk(dd_out == e && dd_oe, "R6", "write word on bus", dd_out, e);
                end
            end
            if (rd_valid) begin
                if (rq.size() == 0) chk(0, "R5", "unexpected read word", rd_data, 0);
                else begin
                    automatic logic [DW-1:0] e = rq.pop_front();
                    chk(rd_data == e, "R5", "read word", rd_data, e);
                end
            end
            if (!ack && prev_ack) begin
                if (hd_chk) chk(hd_run == EXP_HD, "R4", "ack hold cycles", hd_run, EXP_HD);
                seen = 0; su_run = 0; hd_run = 0;
            end
            if (!ack && dd_oe) chk(0, "R6", "dd_oe outside burst", 1, 0);
            prev_low = low; prev_ack = ack;
            prev_rd_low = !dior_n; prev_wr_low = !diow_n;
        end
    end

    task automatic pulse_start(bit rd, int cnt);
        @(negedge clk);
        dir_rd = rd; word_cnt = CW'(cnt); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(string req, int exp_words);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, req, "done seen", done, 1);
        chk(words_done == CW'(exp_words), req, "words_done", words_done, exp_words);
        chk(dmack_n, req, "dmack_n high at done", dmack_n, 1);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
    endtask

    task automatic write_driver(int cnt, int stall_idx, int salt);
        for (int i = 0; i < cnt; i++) begin
            wr_data = DW'(16'h1000 + i * 16'h0101 + salt);
            wr_valid = 1;
            #1;
            while (!wr_ready) begin @(negedge clk); #1; end
            wq.push_back(wr_data);
            @(negedge clk);
            wr_valid = 0;
            if (i == stall_idx) begin
                repeat (40) @(negedge clk);
                chk(!dmack_n && diow_n, "R7", "stalled: ack low, strobe high",
                    {dmack_n, diow_n}, 1);
            end
        end
        wr_valid = 0;
    endtask

    task automatic run_read(int cnt, int moved);
        dev_idx = 0; nstb = 0; expect_wr = 0;
        for (int i = 0; i < moved; i++) rq.push_back(dev_word(i));
        dmarq = 1;
        pulse_start(1, cnt);
        wait_done(moved == cnt ? "R8" : "R9", moved);
        chk(rq.size() == 0, "R5", "read queue drained", rq.size(), 0);
    endtask

    task automatic run_write(int cnt, int stall_idx, int salt);
        nstb = 0; expect_wr = 1; dmarq = 1;
        fork
            write_driver(cnt, stall_idx, salt);
            begin pulse_start(0, cnt); wait_done("R8", cnt); end
        join
        chk(wq.size() == 0, "R6", "write queue drained", wq.size(), 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dmack_n && dior_n && diow_n && !dd_oe && !busy && !done && !rd_valid
            && !wr_ready && cs_n == 2'b11, "R1", "reset outputs", 0, 1);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(dmack_n && dior_n && diow_n && !busy, "R1", "after reset", busy, 0);

        // Plain read burst
        run_read(4, 4);
        // Plain write burst
        run_write(5, -1, 0);
        // Write with a gap in the offered data
        per_chk = 0;
        run_write(4, 1, 7);
        per_chk = 1;
        // One-word write
        run_write(1, -1, 3);
        // Device drops its request after the second strobe
        hd_chk = 0; stop_at = 2;
        run_read(6, 2);
        hd_chk = 1; stop_at = -1;

        // Burst waits for request (R10)
        dmarq = 0; dev_idx = 0; nstb = 0; expect_wr = 0;
        rq.push_back(dev_word(0)); rq.push_back(dev_word(1));
        pulse_start(1, 2);
        repeat (30) @(negedge clk);
        chk(dmack_n && busy, "R10", "no ack before request", dmack_n, 1);
        dmarq = 1;
        wait_done("R10", 2);

        // Zero-count start is ignored (R11)
        pulse_start(0, 0);
        repeat (10) @(negedge clk);
        chk(!busy && dmack_n && !done, "R11", "zero count ignored", busy, 0);

        // Start during a busy burst is ignored (R11)
        dev_idx = 0; nstb = 0; expect_wr = 0;
        for (int i = 0; i < 3; i++) rq.push_back(dev_word(i));
        dmarq = 1;
        pulse_start(1, 3);
        repeat (20) @(negedge clk);
        pulse_start(0, 9);
        wait_done("R11", 3);
        repeat (10) @(negedge clk);
        chk(!busy && diow_n, "R11", "no extra burst", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule